// File: doc/BRIEF.md
# Flash Read Controller with Erase Suspend

This block serves host read requests against a parallel NOR flash bank that is driven by byte-wide command codes and reports progress through a status word. It keeps a record of which mode the bank is in: array read, status report, identification query, or block erase. From that record it decides which command sequence has to come before the data fetch. A bank that is already in array read mode is read at once. A bank that is reporting status is polled until its ready flag shows, then switched back to array read. A bank in query mode is first moved to status reporting.

When a read arrives while a block erase is running and the suspend option is built in, the controller suspends the erase. It polls for ready, switches to array read, fetches the word and then resumes the erase. The host therefore does not wait for the whole erase. Without the suspend option the controller polls until the erase itself finishes. Whatever sequence launched an erase or changed the bank mode tells the controller about it through a one-cycle mode load. Every accepted request gives exactly one response, which carries the data word and an error flag.

The controller is a single state machine. Its states are: idle (S_IDLE), status command (S_STAT_CMD), status poll (S_POLL_RDY), suspend command (S_SUSP_CMD), status after suspend (S_SUSP_STAT), suspend poll (S_POLL_SUSP), erase wait (S_ERASE_WAIT), array command (S_ARRAY_CMD), data fetch (S_FETCH), resume command (S_RESUME_CMD), status after resume (S_RESUME_STAT) and response (S_DONE).

Its transitions are:
- S_IDLE goes to S_FETCH for an array-mode bank, to S_POLL_RDY for a status-mode bank, to S_STAT_CMD for a query-mode bank, and to S_SUSP_CMD or S_ERASE_WAIT for an erasing bank.
- S_STAT_CMD goes to S_POLL_RDY.
- S_POLL_RDY goes to S_ARRAY_CMD on ready and to S_DONE on timeout.
- S_SUSP_CMD goes to S_SUSP_STAT, which goes to S_POLL_SUSP.
- S_POLL_SUSP goes to S_ARRAY_CMD on ready and to S_RESUME_CMD on timeout.
- S_ERASE_WAIT goes to S_ARRAY_CMD on ready.
- S_ARRAY_CMD goes to S_FETCH.
- S_FETCH goes to S_RESUME_CMD when an erase was suspended, and to S_DONE otherwise.
- S_RESUME_CMD goes to S_RESUME_STAT, which goes to S_DONE.
- S_DONE goes back to S_IDLE.

Top module: `flash_rd_suspend_ctrl`

## Requirements
- R1: After reset the controller is idle. `req_ready` is 1, `rsp_valid`, `fl_we` and `fl_oe` are 0, and `chip_mode` is array mode (encoding 0; status is 1, query is 2, erase is 3).
- R2: A request to an array-mode bank issues no command. It returns the word read at `req_addr` with `rsp_err` 0, and the mode stays array.
- R3: With a status-mode bank, the controller reads status and tests bit 7 alone as the ready flag. Once ready is seen, it writes 0xFF, fetches the word, and the mode becomes array.
- R4: When a status poll sees no ready on RDY_TMO consecutive samples, the response has `rsp_err` 1 and `rsp_data` 0. No command is issued and the mode stays status.
- R5: With a query-mode bank, 0x70 is written first and the mode becomes status. The read then proceeds as in R3 and R4.
- R6: With an erasing bank and SUSPEND_EN set, the command order is 0xB0, 0x70, poll, 0xFF, fetch, 0xD0, 0x70. The mode is erase again when the response appears.
- R7: When the suspend poll sees no ready on SUSP_TMO samples, the controller writes 0xD0 then 0x70 and issues no 0xFF. The response has `rsp_err` 1 and `rsp_data` 0, and the mode stays erase.
- R8: With SUSPEND_EN clear, a read to an erasing bank polls status with no time limit until ready. It then writes 0xFF and fetches, and the mode becomes array.
- R9: Every command is written at `req_addr` with its low log2(DATA_W/8) bits cleared. The data fetch uses the full `req_addr`.
- R10: Each accepted request yields exactly one single-cycle `rsp_valid` pulse. `req_ready` is 0 from acceptance until the response has been given, and `fl_we` and `fl_oe` are never high together.
- R11: `mode_load` sets `chip_mode` to `mode_value` only while idle, and holds `req_ready` low in that cycle. A load pulse during a busy transaction has no effect on `chip_mode`.
- R12: A ready flag that first appears on the last allowed poll sample (sample number RDY_TMO or SUSP_TMO) still completes the read without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | ADDR_W | Read byte address |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DATA_W | Read word, zero on error |
| rsp_err | output | 1 | Response reports a timeout |
| mode_load | input | 1 | Load the recorded bank mode |
| mode_value | input | 2 | Mode to load (0 array, 1 status, 2 query, 3 erase) |
| chip_mode | output | 2 | Currently recorded bank mode |
| fl_addr | output | ADDR_W | Flash address |
| fl_we | output | 1 | Flash command write strobe |
| fl_wdata | output | DATA_W | Flash command word |
| fl_oe | output | 1 | Flash read enable |
| fl_rdata | input | DATA_W | Flash read data or status |

## Verification
Two instances are built, one with suspend and one without, and each has its own behavioural bank model. Every run is tried from each of the four recorded modes. Ready latencies are chosen just below, exactly at and just above the poll limit, so that the success path, the last-sample boundary and the timeout path can be told apart. The not-ready status word has every bit set except bit 7, which exposes a poll that tests the wrong bit. Odd addresses separate the aligned command address from the full fetch address. Mode loads pulsed while a transaction is running show whether the recorded mode can be disturbed while busy.

// File: rtl/flrd_pkg.sv
package flrd_pkg;

    typedef enum logic [1:0] {
        MD_ARRAY  = 2'd0,
        MD_STATUS = 2'd1,
        MD_QUERY  = 2'd2,
        MD_ERASE  = 2'd3
    } chip_mode_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STAT_CMD,
        S_POLL_RDY,
        S_SUSP_CMD,
        S_SUSP_STAT,
        S_POLL_SUSP,
        S_ERASE_WAIT,
        S_ARRAY_CMD,
        S_FETCH,
        S_RESUME_CMD,
        S_RESUME_STAT,
        S_DONE
    } seq_state_e;

    localparam logic [7:0] OP_STATUS  = 8'h70;
    localparam logic [7:0] OP_SUSPEND = 8'hB0;
    localparam logic [7:0] OP_RESUME  = 8'hD0;
    localparam logic [7:0] OP_ARRAY   = 8'hFF;
    localparam int         READY_BIT  = 7;

endpackage

// File: rtl/flrd_wait_timer.sv
module flrd_wait_timer #(
    parameter int SUSP_TMO = 8,
    parameter int RDY_TMO  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel_susp,
    output logic expired
);
    localparam int MAX_T = (SUSP_TMO > RDY_TMO) ? SUSP_TMO : RDY_TMO;
    localparam int CNT_W = $clog2(MAX_T + 1);
    localparam logic [CNT_W-1:0] LAST_S = CNT_W'(SUSP_TMO - 1);
    localparam logic [CNT_W-1:0] LAST_R = CNT_W'(RDY_TMO - 1);

    logic [CNT_W-1:0] cnt_q;

    // counts poll samples; cleared whenever no poll is running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        expired = run && (cnt_q == (sel_susp ? LAST_S : LAST_R));
    end

endmodule

// File: rtl/flrd_mode_track.sv
module flrd_mode_track
    import flrd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_en,
    input  chip_mode_e load_val,
    input  logic       ev_status,
    input  logic       ev_array,
    input  logic       ev_erase,
    output chip_mode_e mode
);
    // sequencer events win over an external load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode <= MD_ARRAY;
        else if (ev_erase)
            mode <= MD_ERASE;
        else if (ev_array)
            mode <= MD_ARRAY;
        else if (ev_status)
            mode <= MD_STATUS;
        else if (load_en)
            mode <= load_val;
    end

endmodule

// File: rtl/flrd_seq_fsm.sv
module flrd_seq_fsm
    import flrd_pkg::*;
#(
    parameter bit SUSPEND_EN = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_fire,
    input  chip_mode_e mode_i,
    input  logic       stat_ready,
    input  logic       tmo_expired,
    output logic       idle,
    output logic       cmd_we,
    output logic [7:0] cmd_op,
    output logic       rd_en,
    output logic       fetch_sel,
    output logic       capture,
    output logic       tmr_run,
    output logic       tmr_susp,
    output logic       ev_status,
    output logic       ev_array,
    output logic       ev_erase,
    output logic       rsp_valid,
    output logic       rsp_err
);
    seq_state_e state_q, state_d;
    logic       susp_q;
    logic       err_q;
    logic       erase_entry;

    generate
        if (SUSPEND_EN) begin : g_susp
            assign erase_entry = 1'b1;
        end else begin : g_nosusp
            assign erase_entry = 1'b0;
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_fire) begin
                    unique case (mode_i)
                        MD_ARRAY:  state_d = S_FETCH;
                        MD_STATUS: state_d = S_POLL_RDY;
                        MD_QUERY:  state_d = S_STAT_CMD;
                        MD_ERASE:  state_d = erase_entry ? S_SUSP_CMD : S_ERASE_WAIT;
                        default:   state_d = S_IDLE;
                    endcase
                end
            end
            S_STAT_CMD:    state_d = S_POLL_RDY;
            S_POLL_RDY: begin
                if (stat_ready)       state_d = S_ARRAY_CMD;
                else if (tmo_expired) state_d = S_DONE;
            end
            S_SUSP_CMD:    state_d = S_SUSP_STAT;
            S_SUSP_STAT:   state_d = S_POLL_SUSP;
            S_POLL_SUSP: begin
                if (stat_ready)       state_d = S_ARRAY_CMD;
                else if (tmo_expired) state_d = S_RESUME_CMD;
            end
            S_ERASE_WAIT: begin
                if (stat_ready) state_d = S_ARRAY_CMD;
            end
            S_ARRAY_CMD:   state_d = S_FETCH;
            S_FETCH:       state_d = susp_q ? S_RESUME_CMD : S_DONE;
            S_RESUME_CMD:  state_d = S_RESUME_STAT;
            S_RESUME_STAT: state_d = S_DONE;
            S_DONE:        state_d = S_IDLE;
            default:       state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            susp_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && req_fire) begin
                susp_q <= 1'b0;
                err_q  <= 1'b0;
            end
            if (state_q == S_POLL_SUSP && stat_ready)
                susp_q <= 1'b1;
            if ((state_q == S_POLL_RDY || state_q == S_POLL_SUSP) &&
                !stat_ready && tmo_expired)
                err_q <= 1'b1;
        end
    end

    always_comb begin
        idle      = 1'b0;
        cmd_we    = 1'b0;
        cmd_op    = 8'h00;
        rd_en     = 1'b0;
        fetch_sel = 1'b0;
        capture   = 1'b0;
        tmr_run   = 1'b0;
        tmr_susp  = 1'b0;
        ev_status = 1'b0;
        ev_array  = 1'b0;
        ev_erase  = 1'b0;
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        unique case (state_q)
            S_IDLE:        idle = 1'b1;
            S_STAT_CMD:    begin cmd_we = 1'b1; cmd_op = OP_STATUS; ev_status = 1'b1; end
            S_POLL_RDY:    begin rd_en = 1'b1; tmr_run = 1'b1; end
            S_SUSP_CMD:    begin cmd_we = 1'b1; cmd_op = OP_SUSPEND; end
            S_SUSP_STAT:   begin cmd_we = 1'b1; cmd_op = OP_STATUS; end
            S_POLL_SUSP:   begin rd_en = 1'b1; tmr_run = 1'b1; tmr_susp = 1'b1; end
            S_ERASE_WAIT:  rd_en = 1'b1;
            S_ARRAY_CMD:   begin cmd_we = 1'b1; cmd_op = OP_ARRAY; ev_array = 1'b1; end
            S_FETCH:       begin rd_en = 1'b1; fetch_sel = 1'b1; capture = 1'b1; end
            S_RESUME_CMD:  begin cmd_we = 1'b1; cmd_op = OP_RESUME; end
            S_RESUME_STAT: begin cmd_we = 1'b1; cmd_op = OP_STATUS; ev_erase = 1'b1; end
            S_DONE:        begin rsp_valid = 1'b1; rsp_err = err_q; end
            default:       idle = 1'b0;
        endcase
    end

endmodule

// File: rtl/flash_rd_suspend_ctrl.sv
module flash_rd_suspend_ctrl
    import flrd_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter bit SUSPEND_EN = 1'b1,
    parameter int SUSP_TMO   = 8,
    parameter int RDY_TMO    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_err,
    input  logic              mode_load,
    input  logic [1:0]        mode_value,
    output logic [1:0]        chip_mode,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              fl_we,
    output logic [DATA_W-1:0] fl_wdata,
    output logic              fl_oe,
    input  logic [DATA_W-1:0] fl_rdata
);
    localparam int BUS_BYTES = DATA_W / 8;
    localparam int ALIGN_W   = $clog2(BUS_BYTES);

    logic              idle, cmd_we, rd_en, fetch_sel, capture;
    logic              tmr_run, tmr_susp, tmo_expired;
    logic              ev_status, ev_array, ev_erase, err_flag;
    logic [7:0]        cmd_op;
    logic [ADDR_W-1:0] addr_q, cmd_addr;
    logic [DATA_W-1:0] data_q;
    chip_mode_e        mode_q;
    logic              req_fire;

    assign req_ready = idle && !mode_load;
    assign req_fire  = req_valid && req_ready;

    generate
        if (ALIGN_W == 0) begin : g_noalign
            assign cmd_addr = addr_q;
        end else begin : g_align
            assign cmd_addr = {addr_q[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (req_fire) begin
                addr_q <= req_addr;
                data_q <= '0;
            end
            if (capture)
                data_q <= fl_rdata;
        end
    end

    flrd_seq_fsm #(.SUSPEND_EN(SUSPEND_EN)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_fire    (req_fire),
        .mode_i      (mode_q),
        .stat_ready  (fl_rdata[READY_BIT]),
        .tmo_expired (tmo_expired),
        .idle        (idle),
        .cmd_we      (cmd_we),
        .cmd_op      (cmd_op),
        .rd_en       (rd_en),
        .fetch_sel   (fetch_sel),
        .capture     (capture),
        .tmr_run     (tmr_run),
        .tmr_susp    (tmr_susp),
        .ev_status   (ev_status),
        .ev_array    (ev_array),
        .ev_erase    (ev_erase),
        .rsp_valid   (rsp_valid),
        .rsp_err     (err_flag)
    );

    flrd_wait_timer #(.SUSP_TMO(SUSP_TMO), .RDY_TMO(RDY_TMO)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (tmr_run),
        .sel_susp (tmr_susp),
        .expired  (tmo_expired)
    );

    flrd_mode_track mode_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (mode_load && idle),
        .load_val  (chip_mode_e'(mode_value)),
        .ev_status (ev_status),
        .ev_array  (ev_array),
        .ev_erase  (ev_erase),
        .mode      (mode_q)
    );

    assign chip_mode = mode_q;
    assign rsp_err   = err_flag;
    assign rsp_data  = err_flag ? '0 : data_q;
    assign fl_we     = cmd_we;
    assign fl_oe     = rd_en;
    assign fl_wdata  = DATA_W'(cmd_op);
    assign fl_addr   = fetch_sel ? addr_q : cmd_addr;

endmodule

// File: rtl/flrd_checker.sv
module flrd_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_data,
    input logic              fl_we,
    input logic              fl_oe,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [DATA_W-1:0] fl_wdata
);
    localparam int ALIGN_W = $clog2(DATA_W / 8);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << ALIGN_W) - 1);

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_oe));

    p_rsp_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_cmd_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we |-> ((fl_addr & LOW_MASK) == '0));

    p_err_zero_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_data == '0));

    p_suspend_then_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we && fl_wdata == DATA_W'(8'hB0)) |=> (fl_we && fl_wdata == DATA_W'(8'h70)));

    p_resume_then_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we && fl_wdata == DATA_W'(8'hD0)) |=> (fl_we && fl_wdata == DATA_W'(8'h70)));

    p_array_then_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we && fl_wdata == DATA_W'(8'hFF)) |=> (fl_oe && !fl_we));

endmodule

bind flash_rd_suspend_ctrl flrd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_data  (rsp_data),
    .fl_we     (fl_we),
    .fl_oe     (fl_oe),
    .fl_addr   (fl_addr),
    .fl_wdata  (fl_wdata)
);

// File: tb/flrd_flash_model.sv
module flrd_flash_model (
    input  logic        clk,
    input  logic        preset,
    input  logic [1:0]  preset_mode,
    input  logic        clear,
    input  int          lat,
    input  logic [15:0] exp_caddr,
    input  logic        we,
    input  logic        oe,
    input  logic [15:0] addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output int          log_cnt,
    output logic [63:0] log_vec,
    output logic        addr_bad
);
    logic [1:0] fm;   // 0 array, 1 status, 2 query
    int         cnt;

    always_ff @(posedge clk) begin
        if (preset || clear) begin
            if (preset) fm <= preset_mode;
            cnt      <= 0;
            log_cnt  <= 0;
            log_vec  <= '0;
            addr_bad <= 1'b0;
        end else if (we) begin
            if (log_cnt < 8) log_vec[8*log_cnt +: 8] <= wdata[7:0];
            log_cnt <= log_cnt + 1;
            if (addr != exp_caddr) addr_bad <= 1'b1;
            cnt <= 0;
            fm  <= (wdata[7:0] == 8'hFF) ? 2'd0 : 2'd1;
        end else if (oe && fm == 2'd1) begin
            cnt <= cnt + 1;
        end
    end

    always_comb begin
        if (fm == 2'd0)      rdata = {addr[7:0], ~addr[15:8]};
        else if (fm == 2'd1) rdata = (cnt >= lat) ? 16'h0080 : 16'hFF7F;
        else                 rdata = 16'h0051;
    end

endmodule

// File: tb/flash_rd_suspend_ctrl_tb_top.sv
module flash_rd_suspend_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SUSP_TMO   = 8;
    localparam int RDY_TMO    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        req_valid  [2];
    logic [15:0] req_addr   [2];
    logic        req_ready  [2];
    logic        rsp_valid  [2];
    logic [15:0] rsp_data   [2];
    logic        rsp_err    [2];
    logic        mode_load  [2];
    logic [1:0]  mode_value [2];
    logic [1:0]  chip_mode  [2];
    logic [15:0] fl_addr    [2];
    logic        fl_we      [2];
    logic [15:0] fl_wdata   [2];
    logic        fl_oe      [2];
    logic [15:0] fl_rdata   [2];
    logic        m_preset   [2];
    logic [1:0]  m_pmode    [2];
    logic        m_clear    [2];
    int          m_lat      [2];
    logic [15:0] m_caddr    [2];
    int          m_lcnt     [2];
    logic [63:0] m_lvec     [2];
    logic        m_abad     [2];

    // instance 0 has suspend, instance 1 does not
    for (genvar g = 0; g < 2; g++) begin : g_dut
        flash_rd_suspend_ctrl #(
            .ADDR_W(16), .DATA_W(16), .SUSPEND_EN(g == 0),
            .SUSP_TMO(SUSP_TMO), .RDY_TMO(RDY_TMO)
        ) dut_i (
            .clk(clk), .rst_n(rst_n),
            .req_valid(req_valid[g]), .req_addr(req_addr[g]), .req_ready(req_ready[g]),
            .rsp_valid(rsp_valid[g]), .rsp_data(rsp_data[g]), .rsp_err(rsp_err[g]),
            .mode_load(mode_load[g]), .mode_value(mode_value[g]), .chip_mode(chip_mode[g]),
            .fl_addr(fl_addr[g]), .fl_we(fl_we[g]), .fl_wdata(fl_wdata[g]),
            .fl_oe(fl_oe[g]), .fl_rdata(fl_rdata[g])
        );
        flrd_flash_model model_i (
            .clk(clk), .preset(m_preset[g]), .preset_mode(m_pmode[g]), .clear(m_clear[g]),
            .lat(m_lat[g]), .exp_caddr(m_caddr[g]), .we(fl_we[g]), .oe(fl_oe[g]),
            .addr(fl_addr[g]), .wdata(fl_wdata[g]), .rdata(fl_rdata[g]),
            .log_cnt(m_lcnt[g]), .log_vec(m_lvec[g]), .addr_bad(m_abad[g])
        );
    end

    int total = 0;
    int bad = 0;
    int cycles = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] arr_word(input logic [15:0] a);
        return {a[7:0], ~a[15:8]};
    endfunction

    // expected command list, error flag and final mode from the requirements
    task automatic expect_seq(input int w, input int mode, input int lat,
                              output logic [63:0] cmds, output int n,
                              output bit ok, output int endm);
        cmds = '0; n = 0; ok = 1'b1; endm = 0;
        case (mode)
            0: begin n = 0; ok = 1'b1; endm = 0; end
            1, 2: begin
                if (mode == 2) begin cmds[8*n +: 8] = 8'h70; n++; end
                ok = (lat < RDY_TMO);
                if (ok) begin cmds[8*n +: 8] = 8'hFF; n++; endm = 0; end
                else endm = 1;
            end
            default: begin
                if (w == 0) begin
                    cmds[8*n +: 8] = 8'hB0; n++;
                    cmds[8*n +: 8] = 8'h70; n++;
                    ok = (lat < SUSP_TMO);
                    if (ok) begin cmds[8*n +: 8] = 8'hFF; n++; end
                    cmds[8*n +: 8] = 8'hD0; n++;
                    cmds[8*n +: 8] = 8'h70; n++;
                    endm = 3;
                end else begin
                    cmds[8*n +: 8] = 8'hFF; n++;
                    ok = 1'b1; endm = 0;
                end
            end
        endcase
    endtask

    task automatic run_read(input int w, input int mode, input int lat,
                            input logic [15:0] addr, input bit poke, input string tag);
        logic [63:0] ecmd;
        int          en, endm, waitc;
        bit          eok;
        expect_seq(w, mode, lat, ecmd, en, eok, endm);
        @(negedge clk);
        m_preset[w]   = 1'b1;
        m_pmode[w]    = (mode == 0) ? 2'd0 : (mode == 2) ? 2'd2 : 2'd1;
        m_lat[w]      = lat;
        m_caddr[w]    = {addr[15:1], 1'b0};
        mode_load[w]  = 1'b1;
        mode_value[w] = 2'(mode);
        req_valid[w]  = 1'b1;
        req_addr[w]   = addr;
        #1;
        chk(req_ready[w] == 1'b0, "R11", {tag, " ready blocked by load"}, req_ready[w], 0);
        @(negedge clk);
        m_preset[w]  = 1'b0;
        mode_load[w] = 1'b0;
        #1;
        chk(chip_mode[w] == 2'(mode), "R11", {tag, " mode loaded"}, chip_mode[w], mode);
        chk(req_ready[w] == 1'b1, "R10", {tag, " ready idle"}, req_ready[w], 1);
        @(negedge clk);
        req_valid[w] = 1'b0;
        chk(req_ready[w] == 1'b0, "R10", {tag, " busy after accept"}, req_ready[w], 0);
        if (poke) begin
            mode_load[w]  = 1'b1;
            mode_value[w] = 2'(mode) ^ 2'd1;
        end
        waitc = 0;
        while (!rsp_valid[w] && waitc < 500) begin
            @(negedge clk);
            mode_load[w] = 1'b0;
            waitc++;
        end
        mode_load[w] = 1'b0;
        chk(rsp_valid[w] == 1'b1, "R10", {tag, " response seen"}, rsp_valid[w], 1);
        chk(rsp_err[w] == !eok, eok ? "R12" : "R4", {tag, " error flag"}, rsp_err[w], !eok);
        chk(rsp_data[w] == (eok ? arr_word(addr) : 16'h0), "R2",
            {tag, " data"}, rsp_data[w], eok ? arr_word(addr) : 16'h0);
        chk(chip_mode[w] == 2'(endm), poke ? "R11" : "R6", {tag, " mode after"}, chip_mode[w], endm);
        @(negedge clk);
        chk(rsp_valid[w] == 1'b0, "R10", {tag, " single pulse"}, rsp_valid[w], 0);
        chk(m_lcnt[w] == en, "R3", {tag, " command count"}, m_lcnt[w], en);
        chk(m_lvec[w] == ecmd, (mode == 3) ? ((w == 0) ? "R7" : "R8") : "R5",
            {tag, " command order"}, m_lvec[w], ecmd);
        chk(m_abad[w] == 1'b0, "R9", {tag, " command address aligned"}, m_abad[w], 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int w = 0; w < 2; w++) begin
            req_valid[w] = 0; req_addr[w] = 0; mode_load[w] = 0; mode_value[w] = 0;
            m_preset[w] = 1; m_pmode[w] = 0; m_clear[w] = 0; m_lat[w] = 0; m_caddr[w] = 0;
        end
        repeat (3) @(negedge clk);
        for (int w = 0; w < 2; w++) begin
            chk(req_ready[w] == 1'b1, "R1", "reset ready", req_ready[w], 1);
            chk(rsp_valid[w] == 1'b0, "R1", "reset rsp", rsp_valid[w], 0);
            chk(fl_we[w] == 1'b0 && fl_oe[w] == 1'b0, "R1", "reset strobes", {fl_we[w], fl_oe[w]}, 0);
            chk(chip_mode[w] == 2'd0, "R1", "reset mode", chip_mode[w], 0);
        end
        rst_n = 1'b1;
        // directed corners
        for (int w = 0; w < 2; w++) begin
            run_read(w, 0, 0, 16'h1235, 1'b0, "R2 array odd");
            run_read(w, 1, 2, 16'h4000, 1'b0, "R3 status");
            run_read(w, 1, RDY_TMO - 1, 16'h0101, 1'b0, "R12 status last sample");
            run_read(w, 1, RDY_TMO, 16'h0102, 1'b0, "R4 status timeout");
            run_read(w, 2, 1, 16'h7777, 1'b0, "R5 query");
            run_read(w, 2, RDY_TMO + 3, 16'h7778, 1'b0, "R5 query timeout");
            run_read(w, 3, 3, 16'hABCD, 1'b0, "R6 R8 erase");
            run_read(w, 3, SUSP_TMO - 1, 16'hABCE, 1'b0, "R12 suspend last sample");
            run_read(w, 3, SUSP_TMO, 16'hABCF, 1'b0, "R7 suspend timeout");
            run_read(w, 3, 25, 16'h0F0F, 1'b0, "R8 long erase");
            run_read(w, 0, 0, 16'h2222, 1'b1, "R11 poke array");
            run_read(w, 3, 2, 16'h3333, 1'b1, "R11 poke erase");
        end
        // random mix
        for (int i = 0; i < 60; i++) begin
            int w, md, lt;
            logic [15:0] a;
            w  = int'($urandom_range(0, 1));
            md = int'($urandom_range(0, 3));
            lt = int'($urandom_range(0, SUSP_TMO + 2));
            a  = 16'($urandom);
            run_read(w, md, lt, a, ($urandom_range(0, 3) == 0), "rand");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule